// File: doc/BRIEF.md
# Two-Digit Overlapped Radix-2 SRT Iteration Stage

This block performs one clocked step of a radix-2 SRT divider and retires two signed quotient digits in that step. The partial remainder arrives in carry-save form, together with the normalized divisor. The stage produces the remainder two radix-2 steps later, still in carry-save form, along with the two digits it selected. All outputs are registered. A divider wraps the block in a loop: the outputs are fed back as the next inputs, and the digits are collected into the quotient. Loading new operands is done outside the block.

The second digit is not found by running selection on the result of the first subtraction. Three small speculative units work in parallel with the first selection. Each one assumes a different first digit (+1, 0 or -1). It applies the matching divisor multiple to a narrow window of the upper remainder bits and selects a second digit from the result. Once the first digit is known, it steers a multiplexer that picks one of the three candidates. The picked digit then drives the second full-width carry-save adder as its late input. The datapath keeps exactly two full-width carry-save adders. Only the selection logic is replicated.

Fixed-point format, with W bits per word in two's complement: bit W-1 carries weight -4, bit W-2 carries 2, bit W-3 carries 1, and the remaining W-3 bits are fraction. A normalized divisor lies in [1/2, 1). Its top three bits are 0 and bit W-4 is 1.

Top module: `srt2x_stage`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the stage clears both remainder words and both digit outputs to zero from the next edge on.
- R2: Each digit output uses the code 2'b10 for +1, 2'b01 for -1 and 2'b00 for 0. The code 2'b11 never appears.
- R3: The first digit comes from the estimate E. E is the 4-bit wrap-around sum of bits W-1..W-4 of the doubled sum word and of the doubled carry word, read as a signed value in units of 1/2. The digit is +1 when E >= 0, 0 when E = -1/2, and -1 when E <= -1.
- R4: The second digit equals the digit that the R3 rule yields when applied to the intermediate remainder that the first digit produced. This makes the stage equal to two successive non-overlapped steps.
- R5: Each of the two steps doubles both words and then forms sum = a^b^m and carry = (majority(a,b,m) << 1) | cin. For digit +1, m is the inverted divisor and cin = 1. For digit -1, m is the divisor and cin = 0. For digit 0, m and cin are both 0.
- R6: The output value (sum+carry mod 2^W) equals 4*(input value) - (2*first + second)*D, modulo 2^W.
- R7: If the input value v (signed) satisfies |v| <= D and D is normalized, then the signed output value also lies within [-D, D].
- R8: The outputs change only at rising clock edges. They reflect the inputs sampled at the previous edge, so the latency is one cycle.
- R9: Start from the remainder x with |x| <= D and feed the outputs back for N cycles, collecting Q = 4Q + 2*first + second each cycle. The final remainder P then satisfies x*4^N = Q*D + P and |P| <= D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rem_sum_i | input | W | Current remainder, sum word |
| rem_carry_i | input | W | Current remainder, carry word |
| divisor_i | input | W | Normalized divisor D |
| rem_sum_o | output | W | Remainder two steps on, sum word (registered) |
| rem_carry_o | output | W | Remainder two steps on, carry word (registered) |
| digit_hi_o | output | 2 | First (more significant) quotient digit |
| digit_lo_o | output | 2 | Second quotient digit |

## Verification
The stage is driven with several kinds of input:
- A zero remainder.
- Remainders at exactly +D and -D, for both the smallest and the largest divisor. These land on the outer edges of the selection regions.
- Remainders whose doubled estimate falls exactly on -1/2 or just below it. These separate the zero digit from the -1 digit.
- Random remainders split into random carry-save pairs. These exercise the speculative windows when carries ripple in from low bits.

Every cycle the registered words and digits are compared with a behavioural model of two sequential radix-2 steps, so any divergence between the speculative and the chained second digit is visible. Short division runs then feed the outputs back and confirm that the collected quotient and the final remainder reconstruct the dividend exactly.

// File: rtl/srt2x_pkg.sv
`timescale 1ns/1ps
package srt2x_pkg;

  // Signed quotient digit, one bit per sign
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_NEG  = 2'b01,
    DIG_POS  = 2'b10
  } digit_t;

  // Bits of each word fed to a selection estimate (3 integer + 1 fraction)
  localparam int EST_W  = 4;
  // Window width of a speculative adder: estimate bits plus one bit below
  // so that the carries into the estimate are exact
  localparam int SPEC_W = EST_W + 1;
  // Number of possible first digits, hence of speculative units
  localparam int N_CAND = 3;

endpackage

// File: rtl/srt2x_qsel.sv
`timescale 1ns/1ps
module srt2x_qsel
  import srt2x_pkg::*;
#(
  parameter int EW = EST_W
) (
  input  logic [EW-1:0] est_sum,
  input  logic [EW-1:0] est_carry,
  output digit_t        digit
);

  logic [EW-1:0] est;

  always_comb begin
    est = est_sum + est_carry;
    if (!est[EW-1])  digit = DIG_POS;   // estimate >= 0
    else if (&est)   digit = DIG_ZERO;  // estimate == -1/2
    else             digit = DIG_NEG;   // estimate <= -1
  end

endmodule

// File: rtl/srt2x_csa.sv
`timescale 1ns/1ps
module srt2x_csa
  import srt2x_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_sum,
  input  logic [W-1:0] op_carry,
  input  logic [W-1:0] divisor,
  input  digit_t       digit,
  output logic [W-1:0] res_sum,
  output logic [W-1:0] res_carry
);

  logic [W-1:0] mult;
  logic         cin;
  logic [W-2:0] maj;

  always_comb begin
    unique case (digit)
      DIG_POS: begin mult = ~divisor; cin = 1'b1; end
      DIG_NEG: begin mult = divisor;  cin = 1'b0; end
      default: begin mult = '0;       cin = 1'b0; end
    endcase
  end

  assign maj       = (op_sum[W-2:0] & op_carry[W-2:0])
                   | (op_sum[W-2:0] & mult[W-2:0])
                   | (op_carry[W-2:0] & mult[W-2:0]);
  assign res_sum   = op_sum ^ op_carry ^ mult;
  assign res_carry = {maj, cin};

endmodule

// File: rtl/srt2x_spec.sv
`timescale 1ns/1ps
module srt2x_spec
  import srt2x_pkg::*;
#(
  parameter digit_t ASSUMED = DIG_ZERO
) (
  input  logic [SPEC_W-1:0] win_sum,
  input  logic [SPEC_W-1:0] win_carry,
  input  logic [SPEC_W-1:0] win_div,
  output digit_t            digit
);

  logic [SPEC_W-1:0] nxt_sum;
  logic [SPEC_W-1:0] nxt_carry;
  logic              unused_spec;

  // Narrow carry-save step assuming the first digit is ASSUMED
  srt2x_csa #(.W(SPEC_W)) win_csa_i (
    .op_sum   (win_sum),
    .op_carry (win_carry),
    .divisor  (win_div),
    .digit    (ASSUMED),
    .res_sum  (nxt_sum),
    .res_carry(nxt_carry)
  );

  // Lowest window bit only feeds carries; its own result is not needed
  assign unused_spec = nxt_sum[0] ^ nxt_carry[0];

  srt2x_qsel #(.EW(EST_W)) win_sel_i (
    .est_sum  (nxt_sum[SPEC_W-1:1]),
    .est_carry(nxt_carry[SPEC_W-1:1]),
    .digit    (digit)
  );

endmodule

// File: rtl/srt2x_stage.sv
`timescale 1ns/1ps
module srt2x_stage
  import srt2x_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rem_sum_i,
  input  logic [W-1:0] rem_carry_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] rem_sum_o,
  output logic [W-1:0] rem_carry_o,
  output logic [1:0]   digit_hi_o,
  output logic [1:0]   digit_lo_o
);

  localparam int WIN_TOP = W - 2;   // top bit of speculative window

  logic [W-1:0] x1_sum, x1_carry, p1_sum, p1_carry;
  logic [W-1:0] x2_sum, x2_carry, p2_sum, p2_carry;
  digit_t       q_first, q_second, q_chained;
  digit_t       cand [N_CAND];

  // ---- first step: double, select, subtract ----
  assign x1_sum   = {rem_sum_i[W-2:0], 1'b0};
  assign x1_carry = {rem_carry_i[W-2:0], 1'b0};

  srt2x_qsel #(.EW(EST_W)) first_sel_i (
    .est_sum  (x1_sum[W-1 -: EST_W]),
    .est_carry(x1_carry[W-1 -: EST_W]),
    .digit    (q_first)
  );

  srt2x_csa #(.W(W)) step1_csa_i (
    .op_sum   (x1_sum),
    .op_carry (x1_carry),
    .divisor  (divisor_i),
    .digit    (q_first),
    .res_sum  (p1_sum),
    .res_carry(p1_carry)
  );

  // ---- speculative second selection, one unit per possible first digit ----
  for (genvar g = 0; g < N_CAND; g++) begin : g_spec
    localparam digit_t ASSUMED_G = (g == 0) ? DIG_POS :
                                   (g == 1) ? DIG_ZERO : DIG_NEG;
    srt2x_spec #(.ASSUMED(ASSUMED_G)) spec_i (
      .win_sum  (x1_sum[WIN_TOP -: SPEC_W]),
      .win_carry(x1_carry[WIN_TOP -: SPEC_W]),
      .win_div  (divisor_i[WIN_TOP -: SPEC_W]),
      .digit    (cand[g])
    );
  end

  always_comb begin
    unique case (q_first)
      DIG_POS: q_second = cand[0];
      DIG_NEG: q_second = cand[2];
      default: q_second = cand[1];
    endcase
  end

  // ---- second step: selected digit is the late input ----
  assign x2_sum   = {p1_sum[W-2:0], 1'b0};
  assign x2_carry = {p1_carry[W-2:0], 1'b0};

  srt2x_csa #(.W(W)) step2_csa_i (
    .op_sum   (x2_sum),
    .op_carry (x2_carry),
    .divisor  (divisor_i),
    .digit    (q_second),
    .res_sum  (p2_sum),
    .res_carry(p2_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_sum_o   <= '0;
      rem_carry_o <= '0;
      digit_hi_o  <= DIG_ZERO;
      digit_lo_o  <= DIG_ZERO;
    end else begin
      rem_sum_o   <= p2_sum;
      rem_carry_o <= p2_carry;
      digit_hi_o  <= q_first;
      digit_lo_o  <= q_second;
    end
  end

  // ---- checks ----
  // Chained (non-overlapped) selection on the full intermediate remainder
  srt2x_qsel #(.EW(EST_W)) chained_sel_i (
    .est_sum  (x2_sum[W-1 -: EST_W]),
    .est_carry(x2_carry[W-1 -: EST_W]),
    .digit    (q_chained)
  );

  logic         unused_top;
  assign unused_top = ^{rem_sum_i[W-1], rem_carry_i[W-1],
                        p1_sum[W-1], p1_carry[W-1], q_chained};

  function automatic logic [W-1:0] dmul(input logic [1:0] code,
                                        input logic [W-1:0] d,
                                        input logic twice);
    logic [W-1:0] m;
    m = twice ? {d[W-2:0], 1'b0} : d;
    case (code)
      2'b10:   return m;
      2'b01:   return ~m + 1'b1;
      default: return '0;
    endcase
  endfunction

  logic [W-1:0]        in_val, in4_val, out_val;
  logic signed [W-1:0] in_sv, out_sv;
  logic                in_ok;

  assign in_val  = rem_sum_i + rem_carry_i;
  assign in4_val = {in_val[W-3:0], 2'b00};
  assign out_val = rem_sum_o + rem_carry_o;
  assign in_sv   = $signed(in_val);
  assign out_sv  = $signed(out_val);
  assign in_ok   = (divisor_i[W-1:W-3] == 3'b000) && divisor_i[W-4]
                && (in_sv <= $signed(divisor_i)) && (in_sv >= -$signed(divisor_i));

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (rem_sum_o == '0 && rem_carry_o == '0 && digit_hi_o == 2'b00 && digit_lo_o == 2'b00)); // R1

  AST_SPEC_EQUAL: assert property (@(posedge clk) disable iff (rst)
    q_second == q_chained); // R4

  AST_VALUE_EQ: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((out_val + dmul(digit_hi_o, $past(divisor_i), 1'b1)
                      + dmul(digit_lo_o, $past(divisor_i), 1'b0)) == $past(in4_val))); // R6

  AST_RESID_BOUND: assert property (@(posedge clk) disable iff (rst)
    $past(in_ok) |-> ((out_sv <= $signed($past(divisor_i)))
                      && (out_sv >= -$signed($past(divisor_i))))); // R7

endmodule

// File: tb/srt2x_stage_tb.sv
`timescale 1ns/1ps
module srt2x_stage_tb_top;

  localparam int W  = 16;
  localparam int FB = W - 3;                // fraction bits
  localparam longint DMIN = longint'(1) << (FB - 1);
  localparam longint DMAX = (longint'(1) << FB) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] rem_sum_i = '0;
  logic [W-1:0] rem_carry_i = '0;
  logic [W-1:0] divisor_i = W'(DMIN);
  logic [W-1:0] rem_sum_o, rem_carry_o;
  logic [1:0]   digit_hi_o, digit_lo_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  srt2x_stage #(.W(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .rem_sum_i  (rem_sum_i),
    .rem_carry_i(rem_carry_i),
    .divisor_i  (divisor_i),
    .rem_sum_o  (rem_sum_o),
    .rem_carry_o(rem_carry_o),
    .digit_hi_o (digit_hi_o),
    .digit_lo_o (digit_lo_o)
  );

  function automatic longint sval(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint dv(input logic [1:0] code);
    if (code == 2'b10) return 1;
    if (code == 2'b01) return -1;
    return 0;
  endfunction

  // One non-overlapped radix-2 step as the requirements define it
  function automatic void ref_one(input logic [W-1:0] s, c, d,
                                  output logic [1:0] q,
                                  output logic [W-1:0] so, co);
    logic [W-1:0] xs, xc, m;
    logic [3:0]   est;
    logic         ci;
    xs  = s << 1;
    xc  = c << 1;
    est = xs[W-1:W-4] + xc[W-1:W-4];
    if (!est[3])           begin q = 2'b10; m = ~d; ci = 1'b1; end
    else if (est == 4'hF)  begin q = 2'b00; m = '0; ci = 1'b0; end
    else                   begin q = 2'b01; m = d;  ci = 1'b0; end
    so = xs ^ xc ^ m;
    co = (((xs & xc) | (xs & m) | (xc & m)) << 1) | {{(W-1){1'b0}}, ci};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge and check the result one edge later
  task automatic step(input logic [W-1:0] s, c, d, input logic r);
    logic [W-1:0] ps, pc, ms, mc, es, ec, wrap;
    logic [1:0]   e1, e2;
    longint       vin, vout;
    ps = rem_sum_o;
    pc = rem_carry_o;
    rem_sum_i = s; rem_carry_i = c; divisor_i = d; rst = r;
    #1;
    check(rem_sum_o == ps && rem_carry_o == pc, "R8 outputs moved before edge", longint'(rem_sum_o), longint'(ps));
    if (r) begin
      e1 = 2'b00; e2 = 2'b00; es = '0; ec = '0;
    end else begin
      ref_one(s, c, d, e1, ms, mc);
      ref_one(ms, mc, d, e2, es, ec);
    end
    @(negedge clk);
    if (r) begin
      check(rem_sum_o == '0 && rem_carry_o == '0, "R1 remainder after reset", longint'(rem_sum_o), 0);
      check(digit_hi_o == 2'b00 && digit_lo_o == 2'b00, "R1 digits after reset", longint'({digit_hi_o, digit_lo_o}), 0);
    end else begin
      check(digit_hi_o == e1, "R3 first digit", longint'(digit_hi_o), longint'(e1));
      check(digit_lo_o == e2, "R4 second digit", longint'(digit_lo_o), longint'(e2));
      check(rem_sum_o == es, "R5 sum word", longint'(rem_sum_o), longint'(es));
      check(rem_carry_o == ec, "R5 carry word", longint'(rem_carry_o), longint'(ec));
      check(digit_hi_o != 2'b11 && digit_lo_o != 2'b11, "R2 digit code", longint'({digit_hi_o, digit_lo_o}), 0);
      vin  = sval(s + c);
      wrap = W'(4 * vin - (2 * dv(digit_hi_o) + dv(digit_lo_o)) * longint'(d));
      check(rem_sum_o + rem_carry_o == wrap, "R6 value equation", longint'(rem_sum_o + rem_carry_o), longint'(wrap));
      vout = sval(rem_sum_o + rem_carry_o);
      if (vin <= longint'(d) && vin >= -longint'(d))
        check(vout <= longint'(d) && vout >= -longint'(d), "R7 bound", vout, longint'(d));
    end
  endtask

  task automatic split_step(input longint p, input longint d);
    logic [W-1:0] s, c;
    s = W'($urandom());
    c = W'(p) - s;
    step(s, c, W'(d), 1'b0);
  endtask

  task automatic run_div(input longint x, input longint d, input int n);
    logic [W-1:0] s, c;
    longint q, p, lhs;
    s = W'(x); c = '0; q = 0;
    for (int i = 0; i < n; i++) begin
      step(s, c, W'(d), 1'b0);
      q = q * 4 + 2 * dv(digit_hi_o) + dv(digit_lo_o);
      s = rem_sum_o;
      c = rem_carry_o;
    end
    p   = sval(s + c);
    lhs = x * (longint'(1) << (2 * n));
    check(lhs == q * d + p, "R9 dividend reconstruction", q * d + p, lhs);
    check(p <= d && p >= -d, "R9 final remainder bound", p, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: nonzero inputs held during reset
    step(16'h1234, 16'h0F0F, W'(DMAX), 1'b1);
    step(16'h7FFF, 16'h8001, W'(DMIN), 1'b1);
    // zero remainder
    step('0, '0, W'(DMIN), 1'b0);
    step('0, '0, W'(DMAX), 1'b0);
    // remainder at the bound edges, both divisor extremes
    step(W'(DMIN), '0, W'(DMIN), 1'b0);
    step(W'(-DMIN), '0, W'(DMIN), 1'b0);
    step(W'(DMAX), '0, W'(DMAX), 1'b0);
    step(W'(-DMAX), '0, W'(DMAX), 1'b0);
    // estimate straddling -1/2 (R3 zero vs -1 regions)
    step(W'(-(longint'(1) << (FB - 3))), '0, W'(DMIN), 1'b0);
    step(W'(-(longint'(1) << (FB - 2))), '0, W'(DMIN), 1'b0);
    step(W'(-(longint'(1) << (FB - 2)) - 1), '0, W'(DMIN), 1'b0);
    step(W'(-1), '0, W'(DMAX), 1'b0);
    split_step(-(longint'(1) << (FB - 2)), DMAX);
    // random carry-save splits
    for (int i = 0; i < 400; i++) begin
      longint d, p;
      d = DMIN + longint'($urandom_range(0, 32'(DMAX - DMIN)));
      p = longint'($urandom_range(0, 32'(2 * d))) - d;
      split_step(p, d);
    end
    // full divisions by feedback (R9)
    run_div(0, DMIN, 3);
    run_div(DMIN, DMIN, 3);
    run_div(-DMAX, DMAX, 3);
    run_div(1234, 5000, 3);
    for (int i = 0; i < 20; i++) begin
      longint d, x;
      d = DMIN + longint'($urandom_range(0, 32'(DMAX - DMIN)));
      x = longint'($urandom_range(0, 32'(2 * d))) - d;
      run_div(x, d, 3);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule